// File: doc/BRIEF.md
# IA-32 Instruction Length Decoder

This block takes a window of the next fifteen code bytes fetched at the current instruction pointer and works out how many bytes the first 32-bit protected-mode instruction in that window occupies. It walks the instruction part by part: legacy prefixes, an optional 0x0F escape, the opcode, an optional ModR/M byte, an optional SIB byte, a displacement and an immediate. It reports the size of each part, the total length, and the address of the following instruction.

A fetch stage places the window and its pointer on the input with a valid/ready handshake. The result appears registered one cycle after acceptance and stays put until the consumer takes it. Byte 0 of the window, at bits [7:0], is the byte at the pointer. A byte position at or beyond the fifteenth reads as 0x00. Operation is not defined for 16-bit addressing, and the address-size prefix is only counted as a prefix.

Top module: `insn_len_decoder`

## Requirements
- R1: The bytes F0, F2, F3, 26, 2E, 36, 3E, 64, 65, 66 and 67 are prefixes. Any number of them, in any order, before the opcode are counted in `out_pfx`. A 66 among them sets the operand size to 2 bytes, otherwise it is 4.
- R2: A 0F byte directly after the prefixes sets `out_two_byte`, and the next byte is the opcode, decoded with the two-byte rules.
- R3: A one-byte opcode has a ModR/M byte when (op & C4) = 00, or op is 62, 63, 69 or 6B, or op is in 80–8F, C0, C1, C4–C7, D0–D3 or D8–DF, or (op & F6) = F6.
- R4: A two-byte opcode has a ModR/M byte unless it is in 80–8F, 30–3F, C8–CF, 04–0C, or is 0E, 77, A0–A2 or A8–AA.
- R5: A SIB byte is present (`out_sib`) when a ModR/M byte is present, its rm field (bits 2:0) is 100 and its mod field (bits 7:6) is not 11.
- R6: The displacement is 1 byte for mod 01 and 4 bytes for mod 10. It is also 4 bytes for mod 00 with rm 101, or for mod 00 with a SIB byte whose base field (bits 2:0) is 101. In every other case it is 0.
- R7: Fixed one-byte-opcode immediates are as follows. 1 byte: (op & C7) = 04, 6A, 6B, 70–7F, 80, 82, 83, A8, B0–B7, C0, C1, C6, CD, D4, D5, E0–E7, EB, and F6 with ModR/M reg field (bits 5:3) 000. 2 bytes: C2, CA. 3 bytes: C8. 4 bytes: A0–A3.
- R8: Operand-size immediates are 4 bytes, or 2 bytes when a 66 prefix is present. They apply to (op & C7) = 05, 68, 69, 81, A9, B8–BF, C7, E8, E9, F7 with reg field 000, and the two-byte opcodes 80–8F. EA and 9A take the operand size plus 2.
- R9: Two-byte opcodes 70–73, A4, AC, BA, C2 and C4–C6 take a 1-byte immediate.
- R10: `out_len` equals prefixes + escape + 1 + ModR/M + SIB + displacement + immediate, and `out_npos` equals the accepted pointer plus `out_len`, modulo 2^32.
- R11: `out_err` is set when the length exceeds 15, or when all fifteen window bytes are prefixes. In the latter case only `out_err` is defined.
- R12: `in_ready` is high when `out_valid` is low or `out_ready` is high. An accepted input gives `out_valid` with its result in the next cycle, and a result with `out_valid` high and `out_ready` low holds unchanged.
- R13: During and after reset `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Window and pointer are valid |
| in_ready | output | 1 | Decoder can accept a window |
| in_bytes | input | 120 | Code window, byte 0 in bits [7:0] |
| in_ptr | input | 32 | Address of window byte 0 |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_len | output | 5 | Total instruction length in bytes |
| out_npos | output | 32 | Address of the next instruction |
| out_pfx | output | 4 | Number of prefix bytes |
| out_two_byte | output | 1 | 0F escape present |
| out_modrm | output | 1 | ModR/M byte present |
| out_sib | output | 1 | SIB byte present |
| out_disp | output | 3 | Displacement size in bytes |
| out_imm | output | 3 | Immediate size in bytes |
| out_err | output | 1 | Length over 15 or prefixes fill the window |

## Verification
The length rules are driven with plain opcodes, with every ModR/M addressing form that changes the byte count (register direct, 8-bit and 32-bit displacement, SIB with and without a base, and the absolute-address case), and with each immediate class both with and without a 66 prefix. The with/without-66 pairs separate immediates that scale with operand size from fixed ones, such as the A0–A3 offsets. The F6/F7 pairs with different reg fields show whether the immediate depends on ModR/M. Long prefix runs, a fifteen-byte instruction and lengths past the window exercise the error boundary. A stalled consumer with a second window waiting shows that a held result is not overwritten.

// File: rtl/ild_pkg.sv
package ild_pkg;

  // Immediate classes of an opcode
  typedef enum logic [2:0] {
    IK_NONE, IK_B1, IK_B2, IK_B3, IK_ADR4, IK_OSZ, IK_OSZ2
  } imm_kind_e;

  function automatic logic is_prefix(input logic [7:0] b);
    return b inside {8'hF0, 8'hF2, 8'hF3, 8'h26, 8'h2E, 8'h36,
                     8'h3E, 8'h64, 8'h65, 8'h66, 8'h67};
  endfunction

  function automatic logic op1_has_modrm(input logic [7:0] op);
    return ((op & 8'hC4) == 8'h00) ||
           (op inside {8'h62, 8'h63, 8'h69, 8'h6B}) ||
           (op[7:4] == 4'h8) ||
           (op inside {8'hC0, 8'hC1, [8'hC4:8'hC7], [8'hD0:8'hD3], [8'hD8:8'hDF]}) ||
           ((op & 8'hF6) == 8'hF6);
  endfunction

  function automatic logic op2_has_modrm(input logic [7:0] op);
    logic none;
    none = (op[7:4] == 4'h8) || (op[7:4] == 4'h3) || (op[7:3] == 5'b11001) ||
           (op inside {[8'h04:8'h0C], 8'h0E, 8'h77,
                       [8'hA0:8'hA2], [8'hA8:8'hAA]});
    return !none;
  endfunction

  function automatic imm_kind_e op1_imm_kind(input logic [7:0] op, input logic [2:0] reg_f);
    imm_kind_e k;
    k = IK_NONE;
    if (op == 8'hF6)                         k = (reg_f == 3'd0) ? IK_B1 : IK_NONE;
    else if (op == 8'hF7)                    k = (reg_f == 3'd0) ? IK_OSZ : IK_NONE;
    else if ((op & 8'hC7) == 8'h04)          k = IK_B1;
    else if ((op & 8'hC7) == 8'h05)          k = IK_OSZ;
    else if (op inside {8'h6A, 8'h6B, [8'h70:8'h7F], 8'h80, 8'h82, 8'h83, 8'hA8,
                        [8'hB0:8'hB7], 8'hC0, 8'hC1, 8'hC6, 8'hCD, 8'hD4, 8'hD5,
                        [8'hE0:8'hE7], 8'hEB})
                                             k = IK_B1;
    else if (op inside {8'hC2, 8'hCA})       k = IK_B2;
    else if (op == 8'hC8)                    k = IK_B3;
    else if (op inside {[8'hA0:8'hA3]})      k = IK_ADR4;
    else if (op inside {8'h68, 8'h69, 8'h81, 8'hA9, [8'hB8:8'hBF], 8'hC7, 8'hE8, 8'hE9})
                                             k = IK_OSZ;
    else if (op inside {8'hEA, 8'h9A})       k = IK_OSZ2;
    return k;
  endfunction

  function automatic imm_kind_e op2_imm_kind(input logic [7:0] op);
    if (op inside {[8'h70:8'h73], 8'hA4, 8'hAC, 8'hBA, 8'hC2, [8'hC4:8'hC6]})
      return IK_B1;
    if (op[7:4] == 4'h8)
      return IK_OSZ;
    return IK_NONE;
  endfunction

  function automatic logic [2:0] imm_bytes(input imm_kind_e k, input logic osz16);
    case (k)
      IK_B1:   return 3'd1;
      IK_B2:   return 3'd2;
      IK_B3:   return 3'd3;
      IK_ADR4: return 3'd4;
      IK_OSZ:  return osz16 ? 3'd2 : 3'd4;
      IK_OSZ2: return osz16 ? 3'd4 : 3'd6;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic [2:0] disp_bytes(input logic [7:0] modrm, input logic has_sib,
                                            input logic [7:0] sib);
    case (modrm[7:6])
      2'b01:   return 3'd1;
      2'b10:   return 3'd4;
      2'b00:   return ((modrm[2:0] == 3'b101) || (has_sib && sib[2:0] == 3'b101)) ? 3'd4 : 3'd0;
      default: return 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/ild_prefix_scan.sv
module ild_prefix_scan #(
  parameter int WIN_BYTES = 15,
  localparam int PFX_W = $clog2(WIN_BYTES + 1)
) (
  input  logic [WIN_BYTES*8-1:0] win,
  output logic [PFX_W-1:0]       pfx_cnt,
  output logic                   osz16,
  output logic                   pfx_overflow
);
  import ild_pkg::*;

  logic [WIN_BYTES-1:0] is_pfx;
  logic                 found_op;

  for (genvar g = 0; g < WIN_BYTES; g++) begin : g_pfx
    assign is_pfx[g] = is_prefix(win[g*8 +: 8]);
  end

  always_comb begin
    pfx_cnt  = '0;
    osz16    = 1'b0;
    found_op = 1'b0;
    for (int i = 0; i < WIN_BYTES; i++) begin
      if (!found_op) begin
        if (is_pfx[i]) begin
          pfx_cnt = PFX_W'(i + 1);
          if (win[i*8 +: 8] == 8'h66) osz16 = 1'b1;
        end else begin
          found_op = 1'b1;
        end
      end
    end
    pfx_overflow = !found_op;
  end
endmodule

// File: rtl/ild_field_decode.sv
module ild_field_decode #(
  parameter int WIN_BYTES = 15,
  localparam int PFX_W = $clog2(WIN_BYTES + 1),
  localparam int IDX_W = $clog2(WIN_BYTES + 4) + 1,
  localparam int LEN_W = $clog2(WIN_BYTES + 17)
) (
  input  logic [WIN_BYTES*8-1:0] win,
  input  logic [PFX_W-1:0]       pfx_cnt,
  input  logic                   osz16,
  output logic                   two_byte,
  output logic                   has_modrm,
  output logic                   has_sib,
  output logic [2:0]             disp_sz,
  output logic [2:0]             imm_sz,
  output logic [LEN_W-1:0]       len
);
  import ild_pkg::*;

  function automatic logic [7:0] byte_at(input logic [WIN_BYTES*8-1:0] w,
                                         input logic [IDX_W-1:0] idx);
    logic [7:0] r;
    r = 8'h00;
    for (int i = 0; i < WIN_BYTES; i++)
      if (idx == IDX_W'(i)) r = w[i*8 +: 8];
    return r;
  endfunction

  logic [IDX_W-1:0] esc_pos, opc_pos, mr_pos, sib_pos;
  logic [7:0]       opcode, modrm, sib;
  imm_kind_e        kind;

  always_comb begin
    esc_pos   = IDX_W'(pfx_cnt);
    two_byte  = (byte_at(win, esc_pos) == 8'h0F);
    opc_pos   = esc_pos + IDX_W'(two_byte);
    opcode    = byte_at(win, opc_pos);
    mr_pos    = opc_pos + IDX_W'(1);
    sib_pos   = opc_pos + IDX_W'(2);
    has_modrm = two_byte ? op2_has_modrm(opcode) : op1_has_modrm(opcode);
    modrm     = has_modrm ? byte_at(win, mr_pos) : 8'h00;
    has_sib   = has_modrm && (modrm[2:0] == 3'b100) && (modrm[7:6] != 2'b11);
    sib       = has_sib ? byte_at(win, sib_pos) : 8'h00;
    disp_sz   = has_modrm ? disp_bytes(modrm, has_sib, sib) : 3'd0;
    kind      = two_byte ? op2_imm_kind(opcode) : op1_imm_kind(opcode, modrm[5:3]);
    imm_sz    = imm_bytes(kind, osz16);
    len       = LEN_W'(pfx_cnt) + LEN_W'(two_byte) + LEN_W'(1) + LEN_W'(has_modrm) +
                LEN_W'(has_sib) + LEN_W'(disp_sz) + LEN_W'(imm_sz);
  end
endmodule

// File: rtl/insn_len_decoder.sv
module insn_len_decoder #(
  parameter int WIN_BYTES = 15,
  parameter int PTR_W     = 32,
  localparam int PFX_W = $clog2(WIN_BYTES + 1),
  localparam int LEN_W = $clog2(WIN_BYTES + 17)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [WIN_BYTES*8-1:0] in_bytes,
  input  logic [PTR_W-1:0]       in_ptr,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [LEN_W-1:0]       out_len,
  output logic [PTR_W-1:0]       out_npos,
  output logic [PFX_W-1:0]       out_pfx,
  output logic                   out_two_byte,
  output logic                   out_modrm,
  output logic                   out_sib,
  output logic [2:0]             out_disp,
  output logic [2:0]             out_imm,
  output logic                   out_err
);
  // Named internal events, visible to the checker
  logic [PFX_W-1:0] pfx_cnt;
  logic             osz16, pfx_overflow;
  logic             two_byte, has_modrm, has_sib;
  logic [2:0]       disp_sz, imm_sz;
  logic [LEN_W-1:0] len;
  logic             too_long, accept;

  ild_prefix_scan #(.WIN_BYTES(WIN_BYTES)) u_pfx (
    .win(in_bytes), .pfx_cnt(pfx_cnt), .osz16(osz16), .pfx_overflow(pfx_overflow)
  );

  ild_field_decode #(.WIN_BYTES(WIN_BYTES)) u_fld (
    .win(in_bytes), .pfx_cnt(pfx_cnt), .osz16(osz16),
    .two_byte(two_byte), .has_modrm(has_modrm), .has_sib(has_sib),
    .disp_sz(disp_sz), .imm_sz(imm_sz), .len(len)
  );

  assign too_long = (len > LEN_W'(WIN_BYTES));
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_len      <= '0;
      out_npos     <= '0;
      out_pfx      <= '0;
      out_two_byte <= 1'b0;
      out_modrm    <= 1'b0;
      out_sib      <= 1'b0;
      out_disp     <= '0;
      out_imm      <= '0;
      out_err      <= 1'b0;
    end else if (accept) begin
      out_valid    <= 1'b1;
      out_len      <= len;
      out_npos     <= in_ptr + PTR_W'(len);
      out_pfx      <= pfx_cnt;
      out_two_byte <= two_byte;
      out_modrm    <= has_modrm;
      out_sib      <= has_sib;
      out_disp     <= disp_sz;
      out_imm      <= imm_sz;
      out_err      <= too_long || pfx_overflow;
    end else if (out_ready) begin
      out_valid    <= 1'b0;
    end
  end
endmodule

// File: rtl/insn_len_decoder_chk.sv
module insn_len_decoder_chk #(
  parameter int PFX_W = 4,
  parameter int LEN_W = 5,
  parameter int PTR_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [PTR_W-1:0] in_ptr,
  input logic             out_valid,
  input logic             out_ready,
  input logic [LEN_W-1:0] out_len,
  input logic [PTR_W-1:0] out_npos,
  input logic [PFX_W-1:0] out_pfx,
  input logic             out_modrm,
  input logic             out_sib,
  input logic [2:0]       out_disp,
  input logic             out_err
);
  // R12
  accept_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R12
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_len) && $stable(out_npos));

  // R10
  npos_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_npos == $past(in_ptr) + PTR_W'(out_len));

  // R5
  sib_needs_modrm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_sib |-> out_modrm);

  // R6
  disp_size_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_disp == 3'd0 || out_disp == 3'd1 || out_disp == 3'd4));

  // R11
  len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_err |-> out_len <= LEN_W'(15) && out_len > LEN_W'(out_pfx));
endmodule

bind insn_len_decoder insn_len_decoder_chk #(.PFX_W(PFX_W), .LEN_W(LEN_W), .PTR_W(PTR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_ptr(in_ptr),
  .out_valid(out_valid), .out_ready(out_ready), .out_len(out_len), .out_npos(out_npos),
  .out_pfx(out_pfx), .out_modrm(out_modrm), .out_sib(out_sib), .out_disp(out_disp),
  .out_err(out_err)
);

// File: tb/insn_len_decoder_tb_top.sv
module insn_len_decoder_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [119:0] in_bytes = '0;
  logic [31:0]  in_ptr = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [4:0]   out_len;
  logic [31:0]  out_npos;
  logic [3:0]   out_pfx;
  logic         out_two_byte, out_modrm, out_sib, out_err;
  logic [2:0]   out_disp, out_imm;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;  // 250 MHz

  insn_len_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_bytes(in_bytes), .in_ptr(in_ptr), .out_valid(out_valid), .out_ready(out_ready),
    .out_len(out_len), .out_npos(out_npos), .out_pfx(out_pfx), .out_two_byte(out_two_byte),
    .out_modrm(out_modrm), .out_sib(out_sib), .out_disp(out_disp), .out_imm(out_imm),
    .out_err(out_err)
  );

  // Expected word: {err_only, err, len[5], pfx[4], esc, modrm, sib, disp[3], imm[3]}
  function automatic logic [19:0] mk(int eo, int er, int ln, int pf, int es, int mr,
                                     int sb, int ds, int im);
    return {1'(eo), 1'(er), 5'(ln), 4'(pf), 1'(es), 1'(mr), 1'(sb), 3'(ds), 3'(im)};
  endfunction

  localparam int NV = 40;
  // Bytes written in code order, leftmost first
  localparam logic [119:0] VB [NV] = '{
    120'h90_00_00_00_00_00_00_00_00_00_00_00_00_00_00, // R3 plain
    120'h05_78_56_34_12_00_00_00_00_00_00_00_00_00_00, // R8
    120'h66_05_34_12_00_00_00_00_00_00_00_00_00_00_00, // R1 R8
    120'h8B_45_08_00_00_00_00_00_00_00_00_00_00_00_00, // R6 disp8
    120'h8B_04_24_00_00_00_00_00_00_00_00_00_00_00_00, // R5
    120'h8B_05_00_10_00_00_00_00_00_00_00_00_00_00_00, // R6 absolute
    120'h8B_04_25_00_10_00_00_00_00_00_00_00_00_00_00, // R5 R6 sib no base
    120'h8B_84_24_44_33_22_11_00_00_00_00_00_00_00_00, // R6 disp32
    120'hC7_80_04_00_00_00_78_56_34_12_00_00_00_00_00, // R8
    120'h66_C7_80_04_00_00_00_34_12_00_00_00_00_00_00, // R8
    120'h0F_84_10_00_00_00_00_00_00_00_00_00_00_00_00, // R2 R8
    120'h66_0F_84_10_00_00_00_00_00_00_00_00_00_00_00, // R8
    120'h0F_A2_00_00_00_00_00_00_00_00_00_00_00_00_00, // R4
    120'h0F_AF_C1_00_00_00_00_00_00_00_00_00_00_00_00, // R4
    120'h0F_BA_E0_05_00_00_00_00_00_00_00_00_00_00_00, // R9
    120'hF6_C0_12_00_00_00_00_00_00_00_00_00_00_00_00, // R7
    120'hF6_D0_00_00_00_00_00_00_00_00_00_00_00_00_00, // R7
    120'hF7_C0_01_02_03_04_00_00_00_00_00_00_00_00_00, // R8
    120'hF7_D8_00_00_00_00_00_00_00_00_00_00_00_00_00, // R8
    120'hC2_08_00_00_00_00_00_00_00_00_00_00_00_00_00, // R7
    120'hC8_10_00_01_00_00_00_00_00_00_00_00_00_00_00, // R7
    120'hEA_00_00_00_10_08_00_00_00_00_00_00_00_00_00, // R8
    120'h66_9A_00_10_08_00_00_00_00_00_00_00_00_00_00, // R8
    120'hA1_00_10_00_00_00_00_00_00_00_00_00_00_00_00, // R7
    120'h66_A3_00_10_00_00_00_00_00_00_00_00_00_00_00, // R7
    120'hD9_C0_00_00_00_00_00_00_00_00_00_00_00_00_00, // R3
    120'hDD_45_08_00_00_00_00_00_00_00_00_00_00_00_00, // R3
    120'hF3_A4_00_00_00_00_00_00_00_00_00_00_00_00_00, // R1
    120'h2E_3E_26_64_65_36_F2_90_00_00_00_00_00_00_00, // R1
    120'h6B_C0_05_00_00_00_00_00_00_00_00_00_00_00_00, // R3 R7
    120'h69_C0_00_01_00_00_00_00_00_00_00_00_00_00_00, // R3 R8
    120'h0F_05_00_00_00_00_00_00_00_00_00_00_00_00_00, // R4
    120'h0F_0D_08_00_00_00_00_00_00_00_00_00_00_00_00, // R4
    120'h0F_C8_00_00_00_00_00_00_00_00_00_00_00_00_00, // R4
    120'h83_C4_10_00_00_00_00_00_00_00_00_00_00_00_00, // R7
    120'h80_3D_00_20_00_00_07_00_00_00_00_00_00_00_00, // R6 R7
    120'hF0_F2_F3_2E_36_3E_26_64_65_66_67_F0_F0_F0_90, // R10 fifteen bytes
    120'hF0_F2_F3_2E_36_3E_26_64_65_66_67_F0_F0_F0_05, // R11 over length
    120'h66_66_66_66_66_66_66_66_66_66_66_66_66_66_66, // R11 all prefixes
    120'h0F_31_00_00_00_00_00_00_00_00_00_00_00_00_00  // R4
  };
  localparam logic [19:0] VE [NV] = '{
    mk(0,0, 1, 0,0,0,0,0,0), mk(0,0, 5, 0,0,0,0,0,4), mk(0,0, 4, 1,0,0,0,0,2),
    mk(0,0, 3, 0,0,1,0,1,0), mk(0,0, 3, 0,0,1,1,0,0), mk(0,0, 6, 0,0,1,0,4,0),
    mk(0,0, 7, 0,0,1,1,4,0), mk(0,0, 7, 0,0,1,1,4,0), mk(0,0,10, 0,0,1,0,4,4),
    mk(0,0, 9, 1,0,1,0,4,2), mk(0,0, 6, 0,1,0,0,0,4), mk(0,0, 5, 1,1,0,0,0,2),
    mk(0,0, 2, 0,1,0,0,0,0), mk(0,0, 3, 0,1,1,0,0,0), mk(0,0, 4, 0,1,1,0,0,1),
    mk(0,0, 3, 0,0,1,0,0,1), mk(0,0, 2, 0,0,1,0,0,0), mk(0,0, 6, 0,0,1,0,0,4),
    mk(0,0, 2, 0,0,1,0,0,0), mk(0,0, 3, 0,0,0,0,0,2), mk(0,0, 4, 0,0,0,0,0,3),
    mk(0,0, 7, 0,0,0,0,0,6), mk(0,0, 6, 1,0,0,0,0,4), mk(0,0, 5, 0,0,0,0,0,4),
    mk(0,0, 6, 1,0,0,0,0,4), mk(0,0, 2, 0,0,1,0,0,0), mk(0,0, 3, 0,0,1,0,1,0),
    mk(0,0, 2, 1,0,0,0,0,0), mk(0,0, 8, 7,0,0,0,0,0), mk(0,0, 3, 0,0,1,0,0,1),
    mk(0,0, 6, 0,0,1,0,0,4), mk(0,0, 2, 0,1,0,0,0,0), mk(0,0, 3, 0,1,1,0,0,0),
    mk(0,0, 2, 0,1,0,0,0,0), mk(0,0, 3, 0,0,1,0,0,1), mk(0,0, 7, 0,0,1,0,4,1),
    mk(0,0,15,14,0,0,0,0,0), mk(0,1,17,14,0,0,0,0,2), mk(1,1, 0, 0,0,0,0,0,0),
    mk(0,0, 2, 0,1,0,0,0,0)
  };

  function automatic logic [119:0] to_win(input logic [119:0] lit);
    logic [119:0] w;
    for (int i = 0; i < 15; i++) w[i*8 +: 8] = lit[119 - i*8 -: 8];
    return w;
  endfunction

  task automatic check(input string req, input logic ok, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // Drive one window for a single cycle; returns at the sampling point
  task automatic send(input logic [119:0] lit, input logic [31:0] ptr);
    @(negedge clk);
    in_valid = 1'b1;
    in_bytes = to_win(lit);
    in_ptr   = ptr;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [18:0] act;
    repeat (3) @(negedge clk);
    // R13 reset state
    check("R13 valid low in reset", out_valid == 1'b0, 64'(out_valid), 64'd0);
    check("R13 ready high in reset", in_ready == 1'b1, 64'(in_ready), 64'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R13 valid low after reset", out_valid == 1'b0, 64'(out_valid), 64'd0);

    for (int v = 0; v < NV; v++) begin
      logic [31:0] ptr;
      ptr = 32'h0000_1000 + 32'(v) * 32'd16;
      send(VB[v], ptr);
      act = {out_err, out_len, out_pfx, out_two_byte, out_modrm, out_sib, out_disp, out_imm};
      check($sformatf("R12 valid vec%0d", v), out_valid == 1'b1, 64'(out_valid), 64'd1);
      if (VE[v][19]) begin
        check($sformatf("R11 err vec%0d", v), out_err == 1'b1, 64'(out_err), 64'd1);
      end else begin
        check($sformatf("R10 fields vec%0d", v), act == VE[v][18:0], 64'(act), 64'(VE[v][18:0]));
        check($sformatf("R10 npos vec%0d", v), out_npos == ptr + 32'(VE[v][17:13]),
              64'(out_npos), 64'(ptr + 32'(VE[v][17:13])));
      end
    end

    // R10 pointer wrap: 05 imm32 at FFFF_FFFE
    send(120'h05_00_00_00_00_00_00_00_00_00_00_00_00_00_00, 32'hFFFF_FFFE);
    check("R10 npos wrap", out_npos == 32'd3, 64'(out_npos), 64'd3);

    // R12 stall: result held, second window not accepted
    @(negedge clk);
    out_ready = 1'b0;
    send(120'h90_00_00_00_00_00_00_00_00_00_00_00_00_00_00, 32'h2000);
    check("R12 ready low on stall", in_ready == 1'b0, 64'(in_ready), 64'd0);
    in_valid = 1'b1;
    in_bytes = to_win(120'h0F_84_10_00_00_00_00_00_00_00_00_00_00_00_00);
    in_ptr   = 32'h3000;
    @(negedge clk);
    @(negedge clk);
    check("R12 held len", out_len == 5'd1, 64'(out_len), 64'd1);
    check("R12 held npos", out_npos == 32'h2001, 64'(out_npos), 64'h2001);
    check("R12 held valid", out_valid == 1'b1, 64'(out_valid), 64'd1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R12 next len", out_len == 5'd6, 64'(out_len), 64'd6);
    check("R12 next npos", out_npos == 32'h3006, 64'(out_npos), 64'h3006);
    @(negedge clk);
    check("R12 drains", out_valid == 1'b0, 64'(out_valid), 64'd0);

    // R13 reset mid-stream
    send(120'h90_00_00_00_00_00_00_00_00_00_00_00_00_00_00, 32'h4000);
    rst_n = 1'b0;
    @(negedge clk);
    check("R13 reset clears valid", out_valid == 1'b0, 64'(out_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule